// File: doc/BRIEF.md
# Music Staff Pixel Renderer

This block sits after a display timing generator. Each cycle it takes the current screen coordinate and a flag that marks the visible area. It returns one registered pixel as three 1-bit colour channels. From these it paints a five-line music staff at a fixed place on the screen, a treble clef at a fixed offset from the staff, and a row of note glyphs. The notes come in one at a time through a write strobe that carries an octave, a semitone and a duration.

Each stored note is placed from its pitch relative to the middle staff line. Every diatonic step moves it by half a line spacing. The block picks the stem direction from the side of the middle line the note falls on. It picks the glyph from the duration and adds a sharp sign for black-key semitones. It draws a short ledger line when the note falls outside the five lines. Notes fill slots from left to right in the order they arrive. Writes that arrive after every slot is used are dropped.

Top module: `staff_renderer`

## Requirements
- R1: The colour output is registered. It shows the colour for the coordinate and visible flag sampled at the previous rising clock edge. It is 000 (r,g,b) while the visible flag was low and while reset is active.
- R2: The background is white (111). The staff lines are black (000). They lie on rows STAFF_Y0 + k*LINE_GAP for k = 0..4 and columns STAFF_X0 up to STAFF_X0+STAFF_W-1.
- R3: The clef is a 40x80 sprite with its top-left corner at (STAFF_X0+4, STAFF_Y0-20). It is drawn in blue (001) from a bitmap of 4x4-pixel cells, 10 cells wide and 20 tall. Cell column 4 (pixel columns 16..19) is set in every row, and the top-left cell is clear.
- R4: Up to NUM_NOTES notes are stored in arrival order. Slot i has its 30x60 box starting at column STAFF_X0+NOTE_X0+i*NOTE_PITCH. A write made while all slots are used is ignored.
- R5: The semitone code runs 0 = C to 11 = B. Codes 1, 3, 6, 8 and 10 take the position of the natural below them and set the sharp flag. The diatonic index is C0 D1 E2 F3 G4 A5 B6. Then step = 7*octave + index, d = step - 34 (B4 gives 0), and the head centre row is STAFF_Y0 + 2*LINE_GAP - d*LINE_GAP/2.
- R6: A note with d >= 0 has a stem going down. Its head centre is box row 15, and the stem is box column 10 on the 35 rows below the centre. A note with d < 0 has a stem going up. Its head centre is box row 44, and the stem is box column 21 on the 35 rows above the centre. A whole note has no stem and uses box row 44 for its head centre.
- R7: Duration code 0 is whole, 1 half, 2 quarter and 3 eighth. The head covers box columns 10..21 and centre rows -3..+3. It is filled for quarter and eighth notes and drawn as an outline for half and whole notes. An eighth note adds a 4x4 flag at the stem tip. Stem up uses columns 22..25, rows centre-35..centre-32. Stem down uses columns 11..14, rows centre+32..centre+35.
- R8: A sharp note adds a sign: vertical strokes on box columns 2 and 5 over centre rows -6..+6, and horizontal strokes on centre rows -2 and +2 over columns 0..7.
- R9: When d > 4 or d < -4, a ledger line covers box columns 6..25. It sits on the head centre row when d is even. When d is odd, it sits LINE_GAP/2 rows from the centre toward the staff: below for d > 0, above for d < 0.
- R10: Note ink is red (100) and wins over clef ink, staff lines and background. A pixel where no sprite bit is set shows what lies beneath.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| px_x | input | X_W | Current pixel column |
| px_y | input | Y_W | Current pixel row |
| px_active | input | 1 | High inside the visible area |
| note_we | input | 1 | Appends one note when high |
| note_octave | input | 3 | Octave number of the written note |
| note_semi | input | 4 | Semitone code of the written note, 0 = C |
| note_dur | input | 2 | Duration code of the written note |
| out_r | output | 1 | Red channel |
| out_g | output | 1 | Green channel |
| out_b | output | 1 | Blue channel |

## Verification
The bench goes after notes that straddle the rules. B4 sits exactly on the stem split, so an off-by-one there would turn its stem upward. Odd offsets of five put a ledger on an outer staff line, so a design with the wrong sign on the ledger shift paints red rows off the line. A hollow half-note head lies on a staff line, so a head drawn filled would hide the black line. A whole note has no stem, so a stem added there would show up in the column where quarter and half notes draw theirs. A ninth write into a full list must leave its would-be slot white. Blanking and the clef's ink are probed directly. Random coordinates over several note mixes catch mistakes in the glyph geometry.

// File: rtl/staff_pkg.sv
package staff_pkg;
  typedef enum logic [1:0] {
    DUR_WHOLE   = 2'd0,
    DUR_HALF    = 2'd1,
    DUR_QUARTER = 2'd2,
    DUR_EIGHTH  = 2'd3
  } dur_e;

  localparam int OFS_W = 7;

  typedef struct packed {
    logic [OFS_W-1:0] ofs;    // signed diatonic offset from the middle line
    logic             sharp;
    dur_e             dur;
  } note_t;

  localparam int CLEF_W    = 40;
  localparam int CLEF_H    = 80;
  localparam int CELL      = 4;
  localparam int NOTE_W    = 30;
  localparam int NOTE_H    = 60;
  localparam int HC_UP     = 44;
  localparam int HC_DN     = 15;
  localparam int STEM_LEN  = 35;
  localparam int HEAD_L    = 10;
  localparam int HEAD_R    = 21;
  localparam int HEAD_HALF = 3;
  localparam int REF_STEP  = 34;
  localparam int LEDGER_L  = 6;
  localparam int LEDGER_R  = 25;
endpackage

// File: rtl/pitch_decode.sv
module pitch_decode
  import staff_pkg::*;
(
  input  logic [2:0] octave,
  input  logic [3:0] semi,
  input  dur_e       dur,
  output note_t      note
);
  int   idx;
  int   step;
  logic shp;

  always_comb begin
    shp = 1'b0;
    case (semi)
      4'd0:  idx = 0;
      4'd1:  begin idx = 0; shp = 1'b1; end
      4'd2:  idx = 1;
      4'd3:  begin idx = 1; shp = 1'b1; end
      4'd4:  idx = 2;
      4'd5:  idx = 3;
      4'd6:  begin idx = 3; shp = 1'b1; end
      4'd7:  idx = 4;
      4'd8:  begin idx = 4; shp = 1'b1; end
      4'd9:  idx = 5;
      4'd10: begin idx = 5; shp = 1'b1; end
      default: idx = 6;
    endcase
    step       = int'(octave) * 7 + idx;
    note.ofs   = OFS_W'(step - REF_STEP);
    note.sharp = shp;
    note.dur   = dur;
  end
endmodule

// File: rtl/note_store.sv
module note_store
  import staff_pkg::*;
#(
  parameter int NUM_NOTES = 8,
  parameter int CNT_W     = $clog2(NUM_NOTES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  note_t                 wnote,
  output note_t [NUM_NOTES-1:0] slots,
  output logic  [CNT_W-1:0]     cnt
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_NOTES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = we && (cnt_q < FULL);
    cnt_d  = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < NUM_NOTES; i++) begin : g_slot
    logic slot_en;
    assign slot_en = cnt_en && (cnt_q == CNT_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slots[i] <= '0;
      else if (slot_en) slots[i] <= wnote;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/glyph_gen.sv
module glyph_gen
  import staff_pkg::*;
#(
  parameter int X_W     = 11,
  parameter int Y_W     = 10,
  parameter int BOX_X   = 156,
  parameter int HEAD_Y0 = 220,
  parameter int HALF    = 5
) (
  input  logic [X_W-1:0] px_x,
  input  logic [Y_W-1:0] px_y,
  input  note_t          note,
  input  logic           valid,
  output logic           hit
);
  int   d, hc, lx, ly, lrow;
  logic down, in_box, head_box, head_edge, filled;
  logic stem, flag, shp, ledger;

  always_comb begin
    d      = int'($signed(note.ofs));
    down   = (d >= 0) && (note.dur != DUR_WHOLE);
    hc     = down ? HC_DN : HC_UP;
    lx     = int'(px_x) - BOX_X;
    ly     = int'(px_y) - (HEAD_Y0 - d * HALF - hc);
    in_box = (lx >= 0) && (lx < NOTE_W) && (ly >= 0) && (ly < NOTE_H);

    head_box  = (lx >= HEAD_L) && (lx <= HEAD_R) &&
                (ly >= hc - HEAD_HALF) && (ly <= hc + HEAD_HALF);
    head_edge = (lx == HEAD_L) || (lx == HEAD_R) ||
                (ly == hc - HEAD_HALF) || (ly == hc + HEAD_HALF);
    filled    = (note.dur == DUR_QUARTER) || (note.dur == DUR_EIGHTH);

    if (note.dur == DUR_WHOLE) stem = 1'b0;
    else if (down) stem = (lx == HEAD_L) && (ly > hc) && (ly <= hc + STEM_LEN);
    else           stem = (lx == HEAD_R) && (ly < hc) && (ly >= hc - STEM_LEN);

    if (note.dur != DUR_EIGHTH) flag = 1'b0;
    else if (down) flag = (lx > HEAD_L) && (lx <= HEAD_L + 4) &&
                          (ly >= hc + STEM_LEN - 3) && (ly <= hc + STEM_LEN);
    else           flag = (lx > HEAD_R) && (lx <= HEAD_R + 4) &&
                          (ly >= hc - STEM_LEN) && (ly <= hc - STEM_LEN + 3);

    shp = note.sharp && (lx <= 7) &&
          ((((lx == 2) || (lx == 5)) && (ly >= hc - 6) && (ly <= hc + 6)) ||
           (ly == hc - 2) || (ly == hc + 2));

    if ((d & 1) == 0) lrow = hc;
    else if (d > 0)   lrow = hc + HALF;
    else              lrow = hc - HALF;
    ledger = ((d > 4) || (d < -4)) && (ly == lrow) &&
             (lx >= LEDGER_L) && (lx <= LEDGER_R);

    hit = valid && in_box &&
          ((head_box && (filled || head_edge)) || stem || flag || shp || ledger);
  end
endmodule

// File: rtl/clef_rom.sv
module clef_rom (
  input  logic [4:0] row,
  input  logic [3:0] col,
  output logic       pix
);
  logic [9:0] bits;

  always_comb begin
    case (row)
      5'd0:  bits = 10'b0000100000;
      5'd1:  bits = 10'b0001110000;
      5'd2:  bits = 10'b0010101000;
      5'd3:  bits = 10'b0010101000;
      5'd4:  bits = 10'b0001110000;
      5'd5:  bits = 10'b0000110000;
      5'd6:  bits = 10'b0001100000;
      5'd7:  bits = 10'b0011100000;
      5'd8:  bits = 10'b0110100000;
      5'd9:  bits = 10'b1100101100;
      5'd10: bits = 10'b1001111110;
      5'd11: bits = 10'b1001100011;
      5'd12: bits = 10'b1000100001;
      5'd13: bits = 10'b0100101001;
      5'd14: bits = 10'b0011111110;
      5'd15: bits = 10'b0000100000;
      5'd16: bits = 10'b0000100000;
      5'd17: bits = 10'b0110100000;
      5'd18: bits = 10'b0110100000;
      5'd19: bits = 10'b0011100000;
      default: bits = 10'b0;
    endcase
    pix = (col <= 4'd9) && bits[4'd9 - col];
  end
endmodule

// File: rtl/staff_renderer.sv
module staff_renderer
  import staff_pkg::*;
#(
  parameter int X_W        = 11,
  parameter int Y_W        = 10,
  parameter int NUM_NOTES  = 8,
  parameter int STAFF_X0   = 100,
  parameter int STAFF_Y0   = 200,
  parameter int STAFF_W    = 400,
  parameter int LINE_GAP   = 10,
  parameter int NOTE_X0    = 56,
  parameter int NOTE_PITCH = 36
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [X_W-1:0] px_x,
  input  logic [Y_W-1:0] px_y,
  input  logic           px_active,
  input  logic           note_we,
  input  logic [2:0]     note_octave,
  input  logic [3:0]     note_semi,
  input  logic [1:0]     note_dur,
  output logic           out_r,
  output logic           out_g,
  output logic           out_b
);
  localparam int CNT_W   = $clog2(NUM_NOTES + 1);
  localparam int HALF    = LINE_GAP / 2;
  localparam int HEAD_Y0 = STAFF_Y0 + 2 * LINE_GAP;
  localparam int CLEF_X  = STAFF_X0 + 4;
  localparam int CLEF_Y  = STAFF_Y0 - 20;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  note_t                 wnote;
  note_t [NUM_NOTES-1:0] slots;
  logic  [CNT_W-1:0]     note_cnt;
  logic  [NUM_NOTES-1:0] note_hit;

  pitch_decode u_dec (
    .octave (note_octave),
    .semi   (note_semi),
    .dur    (dur_e'(note_dur)),
    .note   (wnote)
  );

  note_store #(.NUM_NOTES(NUM_NOTES), .CNT_W(CNT_W)) u_store (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (note_we),
    .wnote (wnote),
    .slots (slots),
    .cnt   (note_cnt)
  );

  for (genvar i = 0; i < NUM_NOTES; i++) begin : g_glyph
    glyph_gen #(
      .X_W(X_W), .Y_W(Y_W),
      .BOX_X(STAFF_X0 + NOTE_X0 + i * NOTE_PITCH),
      .HEAD_Y0(HEAD_Y0), .HALF(HALF)
    ) u_glyph (
      .px_x  (px_x),
      .px_y  (px_y),
      .note  (slots[i]),
      .valid (note_cnt > CNT_W'(i)),
      .hit   (note_hit[i])
    );
  end

  // clef sprite
  int         clx, cly;
  logic       clef_in;
  logic [4:0] clef_row;
  logic [3:0] clef_col;
  logic       clef_bit;

  always_comb begin
    clx      = int'(px_x) - CLEF_X;
    cly      = int'(px_y) - CLEF_Y;
    clef_in  = (clx >= 0) && (clx < CLEF_W) && (cly >= 0) && (cly < CLEF_H);
    clef_row = 5'((cly / CELL) & 31);
    clef_col = 4'((clx / CELL) & 15);
  end

  clef_rom u_clef (.row(clef_row), .col(clef_col), .pix(clef_bit));

  // staff lines
  logic on_line;
  always_comb begin
    on_line = 1'b0;
    for (int k = 0; k < 5; k++) begin
      if (int'(px_y) == STAFF_Y0 + k * LINE_GAP) on_line = 1'b1;
    end
    on_line = on_line && (int'(px_x) >= STAFF_X0) && (int'(px_x) < STAFF_X0 + STAFF_W);
  end

  // colour select and output register
  logic [2:0] rgb_d, rgb_q;
  always_comb begin
    if (!px_active)               rgb_d = 3'b000;
    else if (|note_hit)           rgb_d = 3'b100;
    else if (clef_in && clef_bit) rgb_d = 3'b001;
    else if (on_line)             rgb_d = 3'b000;
    else                          rgb_d = 3'b111;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rgb_q <= 3'b000;
    else            rgb_q <= rgb_d;
  end

  assign out_r = rgb_q[2];
  assign out_g = rgb_q[1];
  assign out_b = rgb_q[0];
endmodule

// File: rtl/staff_renderer_chk.sv
module staff_renderer_chk #(
  parameter int NUM_NOTES = 8,
  parameter int CNT_W     = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             px_active,
  input logic             note_we,
  input logic [CNT_W-1:0] cnt,
  input logic [2:0]       rgb
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_NOTES);

  assert_blank_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !px_active |=> (rgb == 3'b000));

  // R2, R3, R10: only the four defined colours ever appear
  assert_palette_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rgb == 3'b000) || (rgb == 3'b001) || (rgb == 3'b100) || (rgb == 3'b111));

  assert_count_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);

  assert_append_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (note_we && (cnt < FULL)) |=> (cnt == $past(cnt) + CNT_W'(1)));

  assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (note_we && (cnt == FULL)) |=> $stable(cnt));

  assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !note_we |=> $stable(cnt));
endmodule

bind staff_renderer staff_renderer_chk #(
  .NUM_NOTES(NUM_NOTES),
  .CNT_W(CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .px_active (px_active),
  .note_we   (note_we),
  .cnt       (note_cnt),
  .rgb       ({out_r, out_g, out_b})
);

// File: tb/tb_staff_renderer.sv
module tb_staff_renderer;
  localparam int CLK_PERIOD = 10;
  localparam int NN   = 8;
  localparam int SX0  = 100;
  localparam int SY0  = 200;
  localparam int SW   = 400;
  localparam int GAP  = 10;
  localparam int NX0  = 56;
  localparam int NP   = 36;
  localparam int CLFX = SX0 + 4;
  localparam int CLFY = SY0 - 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [10:0] px_x;
  logic [9:0]  px_y;
  logic        px_active;
  logic        note_we;
  logic [2:0]  note_octave;
  logic [3:0]  note_semi;
  logic [1:0]  note_dur;
  logic        out_r, out_g, out_b;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int m_oct[NN];
  int m_semi[NN];
  int m_dur[NN];
  int m_cnt = 0;

  staff_renderer dut (
    .clk(clk), .rst_n(rst_n), .px_x(px_x), .px_y(px_y), .px_active(px_active),
    .note_we(note_we), .note_octave(note_octave), .note_semi(note_semi),
    .note_dur(note_dur), .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int natural_idx(int s);
    int t[12] = '{0, 0, 1, 1, 2, 3, 3, 4, 4, 5, 5, 6};
    return t[s];
  endfunction

  function automatic bit is_black_key(int s);
    return (s == 1) || (s == 3) || (s == 6) || (s == 8) || (s == 10);
  endfunction

  // expected ink for stored note n at screen pixel (x, y); geometry per R5..R9
  function automatic bit note_ink(int n, int x, int y);
    int  d, hy, cx, dy, lx, box_top, lshift;
    bit  up, solid, ink;
    d   = m_oct[n] * 7 + natural_idx(m_semi[n]) - 34;
    hy  = SY0 + 2 * GAP - d * (GAP / 2);
    up  = (d < 0) || (m_dur[n] == 0);
    box_top = up ? hy - 44 : hy - 15;
    lx  = x - (SX0 + NX0 + n * NP);
    dy  = y - hy;
    if (lx < 0 || lx > 29 || y < box_top || y > box_top + 59) return 1'b0;
    solid = (m_dur[n] >= 2);
    ink = 1'b0;
    if (lx >= 10 && lx <= 21 && dy >= -3 && dy <= 3)
      ink = solid || lx == 10 || lx == 21 || dy == -3 || dy == 3;
    if (m_dur[n] != 0) begin
      if (up && lx == 21 && dy <= -1 && dy >= -35) ink = 1'b1;
      if (!up && lx == 10 && dy >= 1 && dy <= 35) ink = 1'b1;
    end
    if (m_dur[n] == 3) begin
      if (up && lx >= 22 && lx <= 25 && dy >= -35 && dy <= -32) ink = 1'b1;
      if (!up && lx >= 11 && lx <= 14 && dy >= 32 && dy <= 35) ink = 1'b1;
    end
    if (is_black_key(m_semi[n]) && lx <= 7) begin
      if ((lx == 2 || lx == 5) && dy >= -6 && dy <= 6) ink = 1'b1;
      if (dy == 2 || dy == -2) ink = 1'b1;
    end
    if (d > 4 || d < -4) begin
      cx = d;
      if (cx < 0) cx = -cx;
      lshift = (cx % 2 == 0) ? 0 : ((d > 0) ? GAP / 2 : -(GAP / 2));
      if (dy == lshift && lx >= 6 && lx <= 25) ink = 1'b1;
    end
    return ink;
  endfunction

  // expected colour away from the clef box (R1, R2, R10)
  function automatic logic [2:0] exp_rgb(int x, int y, bit act);
    if (!act) return 3'b000;
    for (int n = 0; n < m_cnt; n++)
      if (note_ink(n, x, y)) return 3'b100;
    if (x >= SX0 && x < SX0 + SW && y >= SY0 && y <= SY0 + 4 * GAP && (y - SY0) % GAP == 0)
      return 3'b000;
    return 3'b111;
  endfunction

  task automatic check(string tag, logic [2:0] got, logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: rgb=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic drive(int x, int y, bit act);
    px_x = 11'(x);
    px_y = 10'(y);
    px_active = act;
  endtask

  // drive at a falling edge, sample at the next falling edge (one register)
  task automatic probe(string tag, int x, int y, bit act, logic [2:0] exp);
    @(negedge clk);
    drive(x, y, act);
    @(negedge clk);
    check(tag, {out_r, out_g, out_b}, exp);
  endtask

  task automatic model_probe(string tag, int x, int y, bit act);
    probe(tag, x, y, act, exp_rgb(x, y, act));
  endtask

  task automatic put_note(int o, int s, int du);
    @(negedge clk);
    note_we = 1'b1;
    note_octave = 3'(o);
    note_semi = 4'(s);
    note_dur = 2'(du);
    @(negedge clk);
    note_we = 1'b0;
    if (m_cnt < NN) begin
      m_oct[m_cnt] = o;
      m_semi[m_cnt] = s;
      m_dur[m_cnt] = du;
      m_cnt++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    note_we = 1'b0;
    drive(300, 220, 1'b1);
    m_cnt = 0;
    repeat (2) @(negedge clk);
    check("R1 reset", {out_r, out_g, out_b}, 3'b000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic random_pixels(int count, string tag);
    for (int k = 0; k < count; k++) begin
      int x, y;
      bit a;
      x = 150 + int'($urandom % 370);
      y = 60 + int'($urandom % 380);
      a = ($urandom % 10) != 0;
      model_probe(tag, x, y, a);
    end
  endtask

  initial begin
    int bx;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    note_we = 1'b0;
    note_octave = '0;
    note_semi = '0;
    note_dur = '0;
    drive(0, 0, 1'b0);
    repeat (3) @(negedge clk);
    check("R1 reset", {out_r, out_g, out_b}, 3'b000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // empty staff
    probe("R2 background", 300, 205, 1'b1, 3'b111);
    probe("R2 staff line", 300, 240, 1'b1, 3'b000);
    probe("R2 line right end", SX0 + SW, 220, 1'b1, 3'b111);
    probe("R1 blanked", 300, 205, 1'b0, 3'b000);
    // clef
    probe("R3 clef spine", CLFX + 17, CLFY + 3, 1'b1, 3'b001);
    probe("R3 clef clear cell", CLFX + 1, CLFY + 1, 1'b1, 3'b111);
    probe("R3 line under clear cell", CLFX + 1, SY0, 1'b1, 3'b000);
    probe("R3 clef over line", CLFX + 18, SY0 + 10, 1'b1, 3'b001);

    // directed note set filling every slot
    put_note(4, 11, 2);  // B4 quarter, d 0
    put_note(4, 7, 1);   // G4 half, d -2
    put_note(6, 0, 3);   // C6 eighth, d 8
    put_note(4, 0, 0);   // C4 whole, d -6
    put_note(5, 6, 2);   // F#5 quarter, d 4
    put_note(3, 9, 3);   // A3 eighth, d -8
    put_note(5, 7, 1);   // G5 half, d 5
    put_note(4, 3, 3);   // D#4 eighth, d -5
    put_note(5, 0, 2);   // ninth write, dropped

    bx = SX0 + NX0;
    model_probe("R10 B4 head on line", bx + 15, 220, 1'b1);
    model_probe("R6 B4 stem down", bx + 10, 250, 1'b1);
    model_probe("R10 G4 hollow head shows line", bx + NP + 15, 230, 1'b1);
    model_probe("R7 G4 head outline", bx + NP + 10, 230, 1'b1);
    model_probe("R9 C6 ledger", bx + 2 * NP + 6, 180, 1'b1);
    model_probe("R9 C6 ledger end", bx + 2 * NP + 26, 180, 1'b1);
    model_probe("R6 C4 whole no stem", bx + 3 * NP + 21, 240, 1'b1);
    model_probe("R9 C4 ledger", bx + 3 * NP + 6, 250, 1'b1);
    model_probe("R8 F#5 sharp stroke", bx + 4 * NP + 2, 204, 1'b1);
    model_probe("R6 F#5 stem tip", bx + 4 * NP + 10, 235, 1'b1);
    model_probe("R6 F#5 past stem tip", bx + 4 * NP + 10, 236, 1'b1);
    model_probe("R7 A3 flag", bx + 5 * NP + 24, 226, 1'b1);
    model_probe("R6 A3 stem tip", bx + 5 * NP + 21, 225, 1'b1);
    model_probe("R9 G5 odd ledger below", bx + 6 * NP + 6, 200, 1'b1);
    model_probe("R9 D#4 odd ledger above", bx + 7 * NP + 6, 240, 1'b1);
    model_probe("R8 D#4 sharp bar", bx + 7 * NP + 0, 247, 1'b1);
    probe("R4 ninth note dropped", bx + 8 * NP + 15, 215, 1'b1, 3'b111);
    probe("R5 B4 head red", bx + 15, 220, 1'b1, 3'b100);
    random_pixels(2500, "R5 R6 R7 R8 R9 random");

    // second mix: random notes after reset
    do_reset();
    begin
      int n;
      n = 1 + int'($urandom % NN);
      for (int k = 0; k < n; k++)
        put_note(2 + int'($urandom % 5), int'($urandom % 12), int'($urandom % 4));
    end
    random_pixels(1500, "R5 R6 R7 R8 R9 R10 random mix");

    // third mix: full list of random notes plus an extra write
    do_reset();
    for (int k = 0; k < NN + 1; k++)
      put_note(2 + int'($urandom % 5), int'($urandom % 12), int'($urandom % 4));
    random_pixels(1500, "R4 R9 R10 random full");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule